// File: doc/BRIEF.md
# Event Buffer Flush Trigger

This block decides when software should empty an event buffer and ship its contents out as a network frame. It keeps a running count of the events held in the buffer. A one-cycle strobe adds one event. Software reports how many events it has taken out through a drain count qualified by a strobe. An interrupt is raised on whichever of two causes comes first: the count climbs past a programmable high watermark, or a periodic timeout elapses while the buffer holds at least one event.

The interrupt stays up until software acknowledges it. A two-bit cause field tells software which condition or conditions fired. Any acknowledge of a pending interrupt restarts the timeout. A flush caused by the watermark therefore also postpones the next timed flush. The timeout period is counted in clock cycles. Its reset value is derived from a clock-frequency parameter so that it equals 2 ms. A newly written period is held back and loaded at the next timer restart.

Top module: `evbuf_flush_trigger`

## Requirements
- R1: After reset `irq_o` is 0, `cause_o` is 0 and `fill_o` is 0. The watermark is `DEPTH*3/4` and the timeout period is `CLK_HZ/500` cycles.
- R2: `fill_o` is updated on the clock edge that samples the strobes. It rises by 1 for `push_i` and falls by `drain_cnt_i` when `drain_vld_i` is set. Both strobes in one cycle apply together.
- R3: The count saturates. It never exceeds `DEPTH`, and a drain larger than the count leaves 0.
- R4: When `fill_o` is strictly greater than the watermark, cause bit 0 (watermark) and `irq_o` are set on the next edge. A count equal to the watermark does not fire. The watermark is written through `wm_wr_i`/`wm_data_i`.
- R5: With the buffer non-empty, the timeout fires exactly P cycles after a timer restart, where P is the active period. It sets cause bit 1 (timeout) and `irq_o`. Expiry is itself a restart.
- R6: The reset period equals 2 ms of clock, which is `CLK_HZ/500` cycles.
- R7: A period written through `per_wr_i`/`per_data_i` does not alter the count in progress. It becomes the active period at the next restart, whether that restart comes from expiry or from acknowledge.
- R8: `irq_ack_i` while `irq_o` is 1 clears `cause_o` and drops `irq_o` on the next edge, unless a cause is present again in that cycle. It also restarts the timer from zero.
- R9: Once set, `irq_o` and its cause bits stay set until acknowledged. `irq_ack_i` while `irq_o` is 0 has no effect.
- R10: A timeout expiry while `fill_o` is 0 raises no interrupt and sets no cause bit. The timer still restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_i | input | 1 | One event written to the buffer |
| drain_vld_i | input | 1 | Qualifies `drain_cnt_i` |
| drain_cnt_i | input | CNT_W | Number of events removed by software |
| wm_wr_i | input | 1 | Write strobe for the high watermark |
| wm_data_i | input | CNT_W | New watermark value |
| per_wr_i | input | 1 | Write strobe for the timeout period |
| per_data_i | input | PERIOD_W | New period in clock cycles |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Flush interrupt, level |
| cause_o | output | 2 | Bit 0 watermark, bit 1 timeout |
| fill_o | output | CNT_W | Current event count |

## Verification
The bench builds the block with `DEPTH=16` and `CLK_HZ=1_000_000`. These values put the default 2 ms timeout at 2000 cycles, so its exact firing cycle can be checked directly against reset. The default watermark becomes 12, so the equal-versus-above boundary and saturation at 16 each take only a handful of pushes. Short programmed periods of 10 to 40 cycles allow cycle-exact checks of deferred period loading and of the restart caused by acknowledging a watermark interrupt.

// File: rtl/evft_pkg.sv
package evft_pkg;
  localparam int CAUSE_N   = 2;
  localparam int CAUSE_WM  = 0;
  localparam int CAUSE_TMO = 1;
  typedef logic [CAUSE_N-1:0] cause_t;
endpackage

// File: rtl/evft_fill_track.sv
module evft_fill_track #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             drain_vld_i,
  input  logic [CNT_W-1:0] drain_cnt_i,
  output logic [CNT_W-1:0] fill_o
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  logic [CNT_W-1:0] fill_q, fill_d;
  logic [CNT_W:0]   sum_w, net_w, drain_x;
  logic             fill_en;

  assign fill_en = push_i | drain_vld_i;
  assign drain_x = {1'b0, drain_cnt_i};

  always_comb begin
    sum_w = {1'b0, fill_q} + (CNT_W+1)'(push_i);
    net_w = sum_w;
    if (drain_vld_i) begin
      if (drain_x > sum_w) net_w = '0;
      else                 net_w = sum_w - drain_x;
    end
    if (net_w > DEPTH_X) fill_d = DEPTH_X[CNT_W-1:0];
    else                 fill_d = net_w[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  assign fill_o = fill_q;

  // R2
  push_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !drain_vld_i && fill_q < DEPTH_X[CNT_W-1:0]) |=> fill_q == $past(fill_q) + 1'b1);

  // R3
  drain_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_vld_i && !push_i && drain_cnt_i >= fill_q) |=> fill_q == '0);

  // R3
  push_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !drain_vld_i && fill_q == DEPTH_X[CNT_W-1:0]) |=> $stable(fill_q));
endmodule

// File: rtl/evft_cfg_regs.sv
module evft_cfg_regs #(
  parameter int              CNT_W    = 11,
  parameter int              PERIOD_W = 32,
  parameter logic [CNT_W-1:0]    WM_RST  = '0,
  parameter logic [PERIOD_W-1:0] PER_RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wm_wr_i,
  input  logic [CNT_W-1:0]    wm_data_i,
  input  logic                per_wr_i,
  input  logic [PERIOD_W-1:0] per_data_i,
  output logic [CNT_W-1:0]    wm_o,
  output logic [PERIOD_W-1:0] per_shadow_o
);
  logic [CNT_W-1:0]    wm_q;
  logic [PERIOD_W-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wm_q <= WM_RST;
    else if (wm_wr_i) wm_q <= wm_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        per_q <= PER_RST;
    else if (per_wr_i) per_q <= per_data_i;
  end

  assign wm_o         = wm_q;
  assign per_shadow_o = per_q;

  // R4
  wm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wm_wr_i |=> $stable(wm_q));
endmodule

// File: rtl/evft_period_timer.sv
module evft_period_timer #(
  parameter int                  PERIOD_W = 32,
  parameter logic [PERIOD_W-1:0] PER_RST  = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                expire_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [PERIOD_W-1:0] act_q, act_d;
  logic [PERIOD_W-1:0] last_w;
  logic                expire_w, reload_w;

  assign last_w   = (act_q == '0) ? '0 : act_q - 1'b1;
  assign expire_w = (cnt_q >= last_w);
  assign reload_w = restart_i | expire_w;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    act_d = act_q;
    if (reload_w) begin
      cnt_d = '0;
      act_d = period_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= PER_RST;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign expire_o = expire_w;

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !expire_o) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !expire_o) |=> $stable(act_q));
endmodule

// File: rtl/evft_irq_ctrl.sv
module evft_irq_ctrl
  import evft_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wm_hit_i,
  input  logic   tmo_i,
  input  logic   empty_i,
  input  logic   ack_i,
  output logic   irq_o,
  output cause_t cause_o,
  output logic   restart_o
);
  cause_t cause_q, cause_d, set_w;
  logic   take_w;

  assign set_w[CAUSE_WM]  = wm_hit_i;
  assign set_w[CAUSE_TMO] = tmo_i & ~empty_i;
  assign take_w           = ack_i & (|cause_q);

  always_comb begin
    for (int i = 0; i < CAUSE_N; i++) begin
      cause_d[i] = (cause_q[i] & ~take_w) | set_w[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign irq_o     = |cause_q;
  assign cause_o   = cause_q;
  assign restart_o = take_w;

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> irq_o && ((cause_o & $past(cause_o)) == $past(cause_o)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i && !wm_hit_i && !tmo_i) |=> !irq_o);

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !wm_hit_i && empty_i) |=> !irq_o);

  // R4
  wm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wm_hit_i |=> cause_o[CAUSE_WM]);
endmodule

// File: rtl/evbuf_flush_trigger.sv
module evbuf_flush_trigger
  import evft_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int CLK_HZ   = 100_000_000,
  parameter int PERIOD_W = 32,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic                drain_vld_i,
  input  logic [CNT_W-1:0]    drain_cnt_i,
  input  logic                wm_wr_i,
  input  logic [CNT_W-1:0]    wm_data_i,
  input  logic                per_wr_i,
  input  logic [PERIOD_W-1:0] per_data_i,
  input  logic                irq_ack_i,
  output logic                irq_o,
  output logic [1:0]          cause_o,
  output logic [CNT_W-1:0]    fill_o
);
  localparam logic [PERIOD_W-1:0] PER_RST = PERIOD_W'(CLK_HZ / 500);
  localparam logic [CNT_W-1:0]    WM_RST  = CNT_W'((DEPTH * 3) / 4);

  logic [CNT_W-1:0]    fill_w, wm_w;
  logic [PERIOD_W-1:0] per_shadow_w;
  logic                tmo_w, restart_w, wm_hit_w, empty_w;
  cause_t              cause_w;

  evft_fill_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .drain_vld_i (drain_vld_i),
    .drain_cnt_i (drain_cnt_i),
    .fill_o      (fill_w)
  );

  evft_cfg_regs #(
    .CNT_W(CNT_W), .PERIOD_W(PERIOD_W), .WM_RST(WM_RST), .PER_RST(PER_RST)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wm_wr_i      (wm_wr_i),
    .wm_data_i    (wm_data_i),
    .per_wr_i     (per_wr_i),
    .per_data_i   (per_data_i),
    .wm_o         (wm_w),
    .per_shadow_o (per_shadow_w)
  );

  evft_period_timer #(.PERIOD_W(PERIOD_W), .PER_RST(PER_RST)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_w),
    .period_i  (per_shadow_w),
    .expire_o  (tmo_w)
  );

  assign wm_hit_w = (fill_w > wm_w);
  assign empty_w  = (fill_w == '0);

  evft_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wm_hit_i  (wm_hit_w),
    .tmo_i     (tmo_w),
    .empty_i   (empty_w),
    .ack_i     (irq_ack_i),
    .irq_o     (irq_o),
    .cause_o   (cause_w),
    .restart_o (restart_w)
  );

  assign cause_o = cause_w;
  assign fill_o  = fill_w;

  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && irq_ack_i && !wm_hit_w && !(tmo_w && !empty_w)) |=> !irq_o);

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= CNT_W'(DEPTH));
endmodule

// File: tb/tb_evbuf_flush_trigger.sv
module tb_evbuf_flush_trigger;
  localparam int DEPTH    = 16;
  localparam int CLK_HZ   = 1_000_000;
  localparam int PERIOD_W = 32;
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int P_DEF    = CLK_HZ / 500;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                push_i, drain_vld_i, wm_wr_i, per_wr_i, irq_ack_i;
  logic [CNT_W-1:0]    drain_cnt_i, wm_data_i;
  logic [PERIOD_W-1:0] per_data_i;
  logic                irq_o;
  logic [1:0]          cause_o;
  logic [CNT_W-1:0]    fill_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  evbuf_flush_trigger #(.DEPTH(DEPTH), .CLK_HZ(CLK_HZ), .PERIOD_W(PERIOD_W)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .drain_vld_i(drain_vld_i),
    .drain_cnt_i(drain_cnt_i), .wm_wr_i(wm_wr_i), .wm_data_i(wm_data_i),
    .per_wr_i(per_wr_i), .per_data_i(per_data_i), .irq_ack_i(irq_ack_i),
    .irq_o(irq_o), .cause_o(cause_o), .fill_o(fill_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      push_i = 1'b1; step(); push_i = 1'b0;
    end
  endtask

  task automatic drain(input int n);
    drain_vld_i = 1'b1; drain_cnt_i = CNT_W'(n); step();
    drain_vld_i = 1'b0; drain_cnt_i = '0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
  endtask

  task automatic set_period(input int p);
    per_wr_i = 1'b1; per_data_i = PERIOD_W'(p); step();
    per_wr_i = 1'b0;
  endtask

  task automatic set_wm(input int w);
    wm_wr_i = 1'b1; wm_data_i = CNT_W'(w); step();
    wm_wr_i = 1'b0;
  endtask

  // expects the timeout irq exactly p edges after the last restart, "already" steps done
  task automatic expect_tmo_at(input int p, input int already, input string req);
    steps(p - 1 - already);
    chk(irq_o == 1'b0, req, int'(irq_o), 0);
    step();
    chk(irq_o == 1'b1 && cause_o == 2'b10, req, int'(cause_o), 2);
  endtask

  task automatic t_reset();
    chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    chk(cause_o == 2'b00, "R1 cause", int'(cause_o), 0);
    chk(fill_o == '0, "R1 fill", int'(fill_o), 0);
  endtask

  task automatic t_default_period();
    push_n(1);
    chk(fill_o == 1, "R2 single push", int'(fill_o), 1);
    expect_tmo_at(P_DEF, 1, "R6 default 2ms period");
    steps(5);
    chk(irq_o == 1'b1 && cause_o == 2'b10, "R9 held until ack", int'(irq_o), 1);
  endtask

  task automatic t_period_reload();
    set_period(40);
    ack();
    chk(irq_o == 1'b0, "R8 ack clears", int'(irq_o), 0);
    expect_tmo_at(40, 0, "R5 programmed period");
    ack();
    steps(5);
    set_period(10);
    expect_tmo_at(40, 6, "R7 write deferred");
    ack();
    expect_tmo_at(10, 0, "R7 new period after restart");
    set_period(100000);
    ack();
  endtask

  task automatic t_fill();
    push_n(4);
    chk(fill_o == 5, "R2 pushes", int'(fill_o), 5);
    push_i = 1'b1; drain(3); push_i = 1'b0;
    chk(fill_o == 3, "R2 push and drain together", int'(fill_o), 3);
    drain(10);
    chk(fill_o == 0, "R3 drain floor", int'(fill_o), 0);
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
    chk(irq_o == 1'b0, "R9 idle ack no effect", int'(irq_o), 0);
  endtask

  task automatic t_watermark();
    push_n(12);
    step();
    chk(irq_o == 1'b0, "R4 equal does not fire", int'(irq_o), 0);
    push_n(1);
    chk(irq_o == 1'b0 && fill_o == 13, "R4 one edge latency", int'(irq_o), 0);
    step();
    chk(irq_o == 1'b1 && cause_o == 2'b01, "R4 watermark cause", int'(cause_o), 1);
    push_n(5);
    chk(fill_o == DEPTH, "R3 ceiling", int'(fill_o), DEPTH);
    drain(14);
    ack();
    chk(irq_o == 1'b0 && cause_o == 2'b00, "R8 ack clears wm", int'(cause_o), 0);
    set_wm(3);
    push_n(2);
    chk(irq_o == 1'b0 && fill_o == 4, "R4 programmed wm latency", int'(irq_o), 0);
    step();
    chk(irq_o == 1'b1 && cause_o == 2'b01, "R4 programmed wm", int'(cause_o), 1);
    drain(4);
    set_period(30);
    ack();
  endtask

  task automatic t_empty_suppress();
    steps(100);
    chk(irq_o == 1'b0, "R10 empty timeout suppressed", int'(irq_o), 0);
    push_n(1);
    begin
      int n;
      n = 0;
      while (!irq_o && n < 40) begin step(); n++; end
      chk(irq_o == 1'b1 && cause_o == 2'b10 && n <= 30, "R10 timer still runs", n, 30);
    end
  endtask

  task automatic t_wm_ack_restart();
    ack();
    push_n(4);
    drain(4);
    chk(irq_o == 1'b1 && cause_o == 2'b01, "R4 wm before restart", int'(cause_o), 1);
    ack();
    expect_tmo_at(30, 0, "R8 ack restarts timer");
  endtask

  initial begin
    rst_n = 1'b0; push_i = 1'b0; drain_vld_i = 1'b0; drain_cnt_i = '0;
    wm_wr_i = 1'b0; wm_data_i = '0; per_wr_i = 1'b0; per_data_i = '0; irq_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_period();
    t_period_reload();
    t_fill();
    t_watermark();
    t_empty_suppress();
    t_wm_ack_restart();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule